// File: doc/BRIEF.md
# Nested-Guest Event Intercept Checker

This block decides whether an event about to be delivered inside a nested guest must instead leave the guest through a VM exit. Each event arrives as a one-cycle request carrying its vector, a set of type flags, an error code and a fault address. The block tests it against the hypervisor's intercept configuration: a 32-bit per-vector exception bitmap, separate enables for NMI, single-byte debug-trap (ICEBP) and plain software-interrupt intercepts, and a decode-assist enable. When an intercept matches, the block emits a one-cycle exit request with an exit code and two 64-bit info words. When nothing matches, no request is made and the event proceeds to normal delivery.

A small state machine tracks whether the next event is the one injected at VM entry. After reset it sits in `ST_CHECK`, where every event is tested. A `vm_entry` pulse moves it to `ST_ARMED` (transition "entry"). The next ordinary event leaves `ST_ARMED` for `ST_CHECK` (transition "inject") and is never intercepted. Any later event, including a fault raised while that injected event is being delivered, is tested. When fault escalation produces a double fault, the caller presents it with `evt_df_escalated`, and only the double-fault bit of the bitmap is consulted.

Top module: `ncp_event_icpt`

## Requirements
- R1: After reset `exit_valid` is low, and the machine is in `ST_CHECK`, so the first event is tested.
- R2: The checks are ordered NMI, then ICEBP, then exception bitmap, then software interrupt. The first check that matches decides the exit.
- R3: An event with vector 2 and flag bit 0 (CPU exception) set, with `icpt_nmi_en` high, exits with code 0x061 and both info words zero.
- R4: An event with flag bit 5 (ICEBP origin) set, with `icpt_icebp_en` high, exits with code 0x088 and both info words zero.
- R5: An event with flag bit 0 set, a vector below 32 and that vector's bitmap bit set exits with code 0x040 plus the vector. Info1 is the zero-extended error code when flag bit 6 is set, otherwise zero. Info2 is the fault address when flag bit 7 is set, otherwise zero.
- R6: The software-interrupt intercept fires only when flag bit 1 (software interrupt) is set, bits 3 (INT3), 4 (INTO) and 5 (ICEBP) are clear, and `icpt_intn_en` is high. It exits with code 0x075. Info1 is the vector when `decode_assist_en` is high, otherwise zero. Info2 is zero.
- R7: An event with flag bit 0 clear never consults the exception bitmap, whatever its vector.
- R8: After a `vm_entry` pulse, the next event without `evt_df_escalated` produces no exit and returns the machine to `ST_CHECK`. The event after it is tested normally.
- R9: An event with `evt_df_escalated` high ignores its vector and flags. It exits with code 0x048 and zero info words exactly when bitmap bit 8 is set. It is never bypassed, and it does not change the state.
- R10: Outputs are registered. `exit_valid` is high for exactly the cycle after an accepted `evt_valid` that matched, and stays low when nothing matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vm_entry | input | 1 | Pulse at VM entry; arms the injected-event bypass |
| evt_valid | input | 1 | Event request strobe |
| evt_vector | input | 8 | Event vector |
| evt_flags | input | 8 | Bit 0: CPU exception. Bit 1: software interrupt. Bit 2: external interrupt. Bit 3: INT3. Bit 4: INTO. Bit 5: ICEBP. Bit 6: error code present. Bit 7: fault address present |
| evt_df_escalated | input | 1 | Event is a double fault produced by escalation |
| evt_err_code | input | 32 | Error code |
| evt_fault_addr | input | 64 | Fault address |
| xcpt_bitmap | input | 32 | Per-vector exception intercept enables |
| icpt_nmi_en | input | 1 | NMI intercept enable |
| icpt_icebp_en | input | 1 | ICEBP intercept enable |
| icpt_intn_en | input | 1 | Software-interrupt intercept enable |
| decode_assist_en | input | 1 | Report the vector in info1 on a software-interrupt exit |
| exit_valid | output | 1 | One-cycle exit request |
| exit_code | output | 12 | Exit code |
| exit_info1 | output | 64 | First info word |
| exit_info2 | output | 64 | Second info word |

## Verification
The hardest cases to reach are those where several intercepts could match at once and only the priority order decides the result. One example is an NMI-vector CPU exception that also carries the ICEBP marker while bit 2 of the bitmap is set. Another is a software interrupt with a low vector whose bitmap bit is set. Directed cases set up each of these overlaps deliberately. Random stimulus then draws flags and vectors from a narrow pool (vectors 0 to 40, with the marker bits frequently set), so that such collisions recur often. The injected-event bypass is reached by interleaving `vm_entry` pulses at random points, including directly before a double-fault escalation.

// File: rtl/ncp_pkg.sv
package ncp_pkg;
    localparam int VEC_W   = 8;
    localparam int FLAG_W  = 8;
    localparam int CODE_W  = 12;
    localparam int INFO_W  = 64;
    localparam int ERR_W   = 32;
    localparam int ADDR_W  = 64;
    localparam int XCPT_N  = 32;

    localparam int FB_CPU   = 0;
    localparam int FB_SOFT  = 1;
    localparam int FB_EXT   = 2;
    localparam int FB_INT3  = 3;
    localparam int FB_INTO  = 4;
    localparam int FB_ICEBP = 5;
    localparam int FB_ERR   = 6;
    localparam int FB_ADDR  = 7;

    localparam int NMI_VEC = 2;
    localparam int DF_VEC  = 8;

    typedef enum logic {
        ST_CHECK = 1'b0,
        ST_ARMED = 1'b1
    } ncp_state_e;
endpackage

// File: rtl/ncp_match.sv
module ncp_match
    import ncp_pkg::*;
#(
    parameter int EXIT_XCPT_BASE = 'h040,
    parameter int EXIT_NMI       = 'h061,
    parameter int EXIT_SWINT     = 'h075,
    parameter int EXIT_ICEBP     = 'h088
) (
    input  logic [VEC_W-1:0]  vector,
    input  logic [FLAG_W-1:0] flags,
    input  logic              df_escalated,
    input  logic [ERR_W-1:0]  err_code,
    input  logic [ADDR_W-1:0] fault_addr,
    input  logic [XCPT_N-1:0] bitmap,
    input  logic              nmi_en,
    input  logic              icebp_en,
    input  logic              intn_en,
    input  logic              decode_assist,
    output logic              hit,
    output logic [CODE_W-1:0] code,
    output logic [INFO_W-1:0] info1,
    output logic [INFO_W-1:0] info2
);
    localparam int IDX_W = $clog2(XCPT_N);

    logic is_cpu, pure_soft, in_range, bm_hit;

    always_comb begin
        is_cpu    = flags[FB_CPU];
        pure_soft = flags[FB_SOFT] && !flags[FB_INT3] && !flags[FB_INTO] && !flags[FB_ICEBP];
        in_range  = (int'(vector) < XCPT_N);
        bm_hit    = is_cpu && in_range && bitmap[vector[IDX_W-1:0]];
    end

    always_comb begin
        hit   = 1'b0;
        code  = '0;
        info1 = '0;
        info2 = '0;
        if (df_escalated) begin
            if (bitmap[DF_VEC]) begin
                hit  = 1'b1;
                code = CODE_W'(EXIT_XCPT_BASE + DF_VEC);
            end
        end else if (is_cpu && int'(vector) == NMI_VEC && nmi_en) begin
            hit  = 1'b1;
            code = CODE_W'(EXIT_NMI);
        end else if (flags[FB_ICEBP] && icebp_en) begin
            hit  = 1'b1;
            code = CODE_W'(EXIT_ICEBP);
        end else if (bm_hit) begin
            hit   = 1'b1;
            code  = CODE_W'(EXIT_XCPT_BASE) + CODE_W'(vector);
            info1 = flags[FB_ERR]  ? INFO_W'(err_code)   : '0;
            info2 = flags[FB_ADDR] ? INFO_W'(fault_addr) : '0;
        end else if (pure_soft && intn_en) begin
            hit   = 1'b1;
            code  = CODE_W'(EXIT_SWINT);
            info1 = decode_assist ? INFO_W'(vector) : '0;
        end
    end

    // R7: a non-CPU event must never yield an exception-range exit
    always_comb begin
        if (!is_cpu && !df_escalated && hit)
            assert_noncpu_range_R7: assert (!(int'(code) >= EXIT_XCPT_BASE &&
                                              int'(code) <  EXIT_XCPT_BASE + XCPT_N));
    end
endmodule

// File: rtl/ncp_event_icpt.sv
module ncp_event_icpt
    import ncp_pkg::*;
#(
    parameter int EXIT_XCPT_BASE = 'h040,
    parameter int EXIT_NMI       = 'h061,
    parameter int EXIT_SWINT     = 'h075,
    parameter int EXIT_ICEBP     = 'h088
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vm_entry,
    input  logic              evt_valid,
    input  logic [7:0]        evt_vector,
    input  logic [7:0]        evt_flags,
    input  logic              evt_df_escalated,
    input  logic [31:0]       evt_err_code,
    input  logic [63:0]       evt_fault_addr,
    input  logic [31:0]       xcpt_bitmap,
    input  logic              icpt_nmi_en,
    input  logic              icpt_icebp_en,
    input  logic              icpt_intn_en,
    input  logic              decode_assist_en,
    output logic              exit_valid,
    output logic [11:0]       exit_code,
    output logic [63:0]       exit_info1,
    output logic [63:0]       exit_info2
);
    ncp_state_e state, state_nx;

    logic              m_hit;
    logic [CODE_W-1:0] m_code;
    logic [INFO_W-1:0] m_info1, m_info2;
    logic              bypass;

    ncp_match #(
        .EXIT_XCPT_BASE(EXIT_XCPT_BASE),
        .EXIT_NMI      (EXIT_NMI),
        .EXIT_SWINT    (EXIT_SWINT),
        .EXIT_ICEBP    (EXIT_ICEBP)
    ) u_match (
        .vector       (evt_vector),
        .flags        (evt_flags),
        .df_escalated (evt_df_escalated),
        .err_code     (evt_err_code),
        .fault_addr   (evt_fault_addr),
        .bitmap       (xcpt_bitmap),
        .nmi_en       (icpt_nmi_en),
        .icebp_en     (icpt_icebp_en),
        .intn_en      (icpt_intn_en),
        .decode_assist(decode_assist_en),
        .hit          (m_hit),
        .code         (m_code),
        .info1        (m_info1),
        .info2        (m_info2)
    );

    // next state: entry arms, injected event disarms
    always_comb begin
        state_nx = state;
        bypass   = 1'b0;
        unique case (state)
            ST_CHECK: begin
                if (vm_entry) state_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (evt_valid && !evt_df_escalated) begin
                    bypass   = 1'b1;
                    state_nx = ST_CHECK;
                end
                if (vm_entry) state_nx = ST_ARMED;
            end
            default: state_nx = ST_CHECK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_CHECK;
        else        state <= state_nx;
    end

    // registered exit request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exit_valid <= 1'b0;
            exit_code  <= '0;
            exit_info1 <= '0;
            exit_info2 <= '0;
        end else begin
            exit_valid <= evt_valid && m_hit && !bypass;
            if (evt_valid && m_hit && !bypass) begin
                exit_code  <= m_code;
                exit_info1 <= m_info1;
                exit_info2 <= m_info2;
            end
        end
    end

    assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exit_valid |-> $past(evt_valid));

    assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && evt_valid && !evt_df_escalated) |=> !exit_valid);

    assert_nmi_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_valid && int'(exit_code) == EXIT_NMI) |-> (exit_info1 == '0 && exit_info2 == '0));

    assert_icebp_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_valid && int'(exit_code) == EXIT_ICEBP) |-> (exit_info1 == '0 && exit_info2 == '0));

    assert_swint_info_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_valid && int'(exit_code) == EXIT_SWINT) |-> (exit_info2 == '0 && exit_info1 < 64'd256));

    assert_df_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_df_escalated && !vm_entry) |=> $stable(state));
endmodule

// File: tb/sim_ncp_event_icpt.sv
module sim_ncp_event_icpt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vm_entry = 1'b0;
    logic        evt_valid = 1'b0;
    logic [7:0]  evt_vector = '0;
    logic [7:0]  evt_flags = '0;
    logic        evt_df_escalated = 1'b0;
    logic [31:0] evt_err_code = '0;
    logic [63:0] evt_fault_addr = '0;
    logic [31:0] xcpt_bitmap = '0;
    logic        icpt_nmi_en = 1'b0;
    logic        icpt_icebp_en = 1'b0;
    logic        icpt_intn_en = 1'b0;
    logic        decode_assist_en = 1'b0;
    logic        exit_valid;
    logic [11:0] exit_code;
    logic [63:0] exit_info1, exit_info2;

    int n_checks = 0;
    int n_fail   = 0;
    bit armed    = 1'b0;

    always #10 clk = ~clk;

    ncp_event_icpt u0 (.*);

    typedef struct packed {
        logic        v;
        logic [11:0] c;
        logic [63:0] i1;
        logic [63:0] i2;
    } exp_t;

    function automatic exp_t model(input bit byp, output string tag);
        exp_t e;
        e = '0;
        tag = "R10";
        if (evt_df_escalated) begin
            tag = "R9";
            if (xcpt_bitmap[8]) begin e.v = 1; e.c = 12'h048; end
        end else if (byp) begin
            tag = "R8";
        end else if (evt_flags[0] && evt_vector == 8'd2 && icpt_nmi_en) begin
            tag = "R3"; e.v = 1; e.c = 12'h061;
        end else if (evt_flags[5] && icpt_icebp_en) begin
            tag = "R4"; e.v = 1; e.c = 12'h088;
        end else if (evt_flags[0] && evt_vector < 8'd32 && xcpt_bitmap[evt_vector[4:0]]) begin
            tag = "R5"; e.v = 1; e.c = 12'h040 + {4'd0, evt_vector};
            if (evt_flags[6]) e.i1 = {32'd0, evt_err_code};
            if (evt_flags[7]) e.i2 = evt_fault_addr;
        end else if (evt_flags[1] && !evt_flags[3] && !evt_flags[4] && !evt_flags[5] && icpt_intn_en) begin
            tag = "R6"; e.v = 1; e.c = 12'h075;
            if (decode_assist_en) e.i1 = {56'd0, evt_vector};
        end else if (!evt_flags[0]) begin
            tag = "R7";
        end
        return e;
    endfunction

    task automatic check(input string req, input exp_t e);
        n_checks++;
        if (exit_valid !== e.v || (e.v && (exit_code !== e.c || exit_info1 !== e.i1 || exit_info2 !== e.i2))) begin
            n_fail++;
            $display("FAIL %s: got v=%0b code=%h i1=%h i2=%h, expected v=%0b code=%h i1=%h i2=%h",
                     req, exit_valid, exit_code, exit_info1, exit_info2, e.v, e.c, e.i1, e.i2);
        end
    endtask

    // present one event; check the registered result one cycle later
    task automatic send(input logic [7:0] vec, input logic [7:0] fl, input logic df, input string force_tag);
        exp_t e;
        string tag;
        bit byp;
        @(negedge clk);
        evt_vector = vec; evt_flags = fl; evt_df_escalated = df;
        evt_err_code = $urandom; evt_fault_addr = {$urandom, $urandom};
        evt_valid = 1'b1;
        byp = armed && !df;
        e = model(byp, tag);
        if (byp) armed = 1'b0;
        @(negedge clk);
        evt_valid = 1'b0;
        check(force_tag != "" ? force_tag : tag, e);
    endtask

    task automatic entry();
        @(negedge clk);
        vm_entry = 1'b1;
        armed = 1'b1;
        @(negedge clk);
        vm_entry = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        exp_t z;
        void'($urandom(32'd4711));
        z = '0;
        repeat (3) @(negedge clk);
        check("R1", z);
        rst_n = 1'b1;

        // R1: first event after reset is tested (not bypassed)
        xcpt_bitmap = 32'h0000_2000;
        send(8'd13, 8'h41, 1'b0, "R1");

        // R3 vs R5: NMI vector with bitmap bit 2 also set
        icpt_nmi_en = 1; icpt_icebp_en = 1; icpt_intn_en = 1; decode_assist_en = 1;
        xcpt_bitmap = 32'hFFFF_FFFF;
        send(8'd2, 8'h21, 1'b0, "R2");
        send(8'd2, 8'hC1, 1'b0, "R3");
        // R4 beats bitmap for #DB-vector with ICEBP marker
        send(8'd1, 8'h21, 1'b0, "R4");
        // R5: page fault with error and address
        send(8'd14, 8'hC1, 1'b0, "R5");
        icpt_nmi_en = 0;
        send(8'd2, 8'h01, 1'b0, "R5");
        // R7: software interrupt at low vector: bitmap ignored, INTn hits
        send(8'd5, 8'h02, 1'b0, "R7");
        // R6: INT3 / INTO / ICEBP markers suppress INTn
        icpt_icebp_en = 0;
        send(8'd3, 8'h0A, 1'b0, "R6");
        send(8'd4, 8'h12, 1'b0, "R6");
        send(8'd1, 8'h22, 1'b0, "R6");
        decode_assist_en = 0;
        send(8'h80, 8'h02, 1'b0, "R6");
        // R7: external interrupt never consults bitmap
        icpt_intn_en = 0;
        send(8'd6, 8'h04, 1'b0, "R7");
        // R10: no match then pulse drops
        xcpt_bitmap = 32'h0;
        send(8'd13, 8'h01, 1'b0, "R10");
        xcpt_bitmap = 32'h0000_0001;
        send(8'd0, 8'h01, 1'b0, "R10");
        @(negedge clk);
        check("R10", z);
        // R8: injected event bypassed, next checked
        xcpt_bitmap = 32'hFFFF_FFFF;
        entry();
        send(8'd14, 8'hC1, 1'b0, "R8");
        send(8'd14, 8'hC1, 1'b0, "R8");
        // R9: df escalation not bypassed and does not disarm
        entry();
        send(8'd0, 8'h00, 1'b1, "R9");
        send(8'd13, 8'h41, 1'b0, "R8");
        xcpt_bitmap = 32'hFFFF_FEFF;
        send(8'd3, 8'h01, 1'b1, "R9");

        // random mix
        for (int k = 0; k < 400; k++) begin
            logic [7:0] v, f;
            xcpt_bitmap = $urandom;
            icpt_nmi_en = 1'($urandom); icpt_icebp_en = 1'($urandom);
            icpt_intn_en = 1'($urandom); decode_assist_en = 1'($urandom);
            v = 8'($urandom_range(0, 40));
            if ($urandom_range(0, 9) == 0) v = 8'($urandom);
            f = 8'($urandom);
            if ($urandom_range(0, 7) == 0) entry();
            send(v, f, ($urandom_range(0, 9) == 0), "");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule